// File: doc/BRIEF.md
# Streaming Parallel Interference Cancellation Stage

This block is one cancellation stage of a multistage detector for asynchronous multi-user spread-spectrum reception. For every bit period it receives a vector of K soft correlator outputs (one per user) together with the hard ±1 decisions that the preceding stage made for all K users. Because the users are not time-aligned, the interference that lands on bit i of one user comes from the neighbouring bits (i-1, i and i+1) of every other user. The stage holds three K×K correlation blocks, one for each of those bit offsets. It subtracts the estimated interference from the soft value and emits a refined hard decision for bit i.

Work proceeds one bit at a time with a fixed latency, and no detection window is kept. A vector that arrives carries the next-bit decisions that bit i still needs, so each arrival releases the result for the bit before it. Since every decision is ±1, each correlation term is simply added or subtracted and no multiplier is needed. Several stages can be chained, each taking its predecessor's decisions. The correlation blocks are loaded through a small write port while the stage is idle.

Top module: `pic_stage`

## Requirements
- R1: `out_dec[k]` holds 0 for +1 and 1 for -1. It is the sign of z_k = y_k(i) - Σ_j c·d_j over the three blocks. A z_k of exactly zero gives 0 (+1).
- R2: The current block (code 1) uses the decisions d(i) of the users. Its entry at row k, column k never affects user k, whatever value is written there.
- R3: The past block (code 0) multiplies the decisions d(i-1) and includes the column equal to the row.
- R4: The next block (code 2) multiplies the decisions d(i+1) carried by the vector that arrives after bit i.
- R5: A decision bit of 0 subtracts the coefficient from y_k. A decision bit of 1 adds it.
- R6: `out_valid` is a one-cycle pulse. It goes high after the (K+2)th rising clock edge that follows the edge at which `in_valid` was sampled, and it is low after each edge before that.
- R7: The first vector after reset produces no output. The first result (bit 0) treats the d(-1) decisions as absent and adds no past-block term.
- R8: A write (`cw_en`) stores `cw_data` at block `cw_blk`, row `cw_row`, column `cw_col`. Block code 3 stores nothing. A write that coincides with `in_valid` or with a job in progress is ignored.
- R9: While reset is held, `out_valid` and `out_dec` are 0. All coefficients are cleared to 0.
- R10: Soft values and coefficients are W-bit two's complement. A full-scale case, with every coefficient at -2^(W-1) and every input at the same extreme, is decided without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | One new bit vector this cycle |
| in_soft | input | K*W | Soft values, user k at bits [k*W +: W] |
| in_dec | input | K | Previous-stage decisions for this bit, 1 means -1 |
| cw_en | input | 1 | Coefficient write strobe |
| cw_blk | input | 2 | Block code: 0 past, 1 current, 2 next |
| cw_row | input | $clog2(K) | Victim user (row) |
| cw_col | input | $clog2(K) | Interfering user (column) |
| cw_data | input | W | Coefficient value, two's complement |
| out_valid | output | 1 | Result pulse |
| out_dec | output | K | Refined decisions for the previous bit, 1 means -1 |

## Verification
The assertions assume that `in_valid` never arrives while a job is running, so consecutive vectors must be at least K+3 cycles apart. They also assume a coefficient load is never timed to race a job. The stimulus sends each vector and then waits out the full latency plus one idle cycle before the next one. It issues writes only during idle cycles, except for the one directed case that checks a write during a job is dropped. Given that spacing, every result pulse traces back to exactly one job, and the coefficient store stays frozen while a job reads it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    BLK_PAST = 2'd0,
    BLK_CUR  = 2'd1,
    BLK_NEXT = 2'd2,
    BLK_NONE = 2'd3
  } blk_e;
  localparam int NBLK = 3;
endpackage

// File: rtl/pic_coef_bank.sv
module pic_coef_bank
  import pic_pkg::*;
#(
  parameter int K  = 4,
  parameter int W  = 12,
  localparam int IW = $clog2(K)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock,
  input  logic                   wr_en,
  input  logic [1:0]             wr_blk,
  input  logic [IW-1:0]          wr_row,
  input  logic [IW-1:0]          wr_col,
  input  logic [W-1:0]           wr_data,
  output logic [NBLK*K*K*W-1:0]  coef_flat
);
  logic wr_ok;
  assign wr_ok = wr_en & ~lock;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    for (genvar r = 0; r < K; r++) begin : g_row
      for (genvar c = 0; c < K; c++) begin : g_col
        logic         hit;
        logic [W-1:0] q;
        assign hit = wr_ok && (wr_blk == 2'(b)) && (wr_row == IW'(r)) && (wr_col == IW'(c));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= '0;
          else if (hit) q <= wr_data;
        end
        assign coef_flat[((b*K + r)*K + c)*W +: W] = q;
      end
    end
  end

  // R8: the store stays frozen for any cycle it is locked
  a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(coef_flat));
endmodule

// File: rtl/pic_row_eval.sv
module pic_row_eval
  import pic_pkg::*;
#(
  parameter int K  = 4,
  parameter int W  = 12,
  parameter int AW = 16,
  localparam int IW = $clog2(K)
) (
  input  logic [NBLK*K*K*W-1:0] coef_flat,
  input  logic [IW-1:0]         row,
  input  logic [K*W-1:0]        y_flat,
  input  logic [K-1:0]          d_past,
  input  logic                  past_ok,
  input  logic [K-1:0]          d_cur,
  input  logic [K-1:0]          d_next,
  output logic                  neg
);
  logic signed [AW-1:0] z;
  logic signed [W-1:0]  yv, c;

  always_comb begin
    yv = y_flat[int'(row)*W +: W];
    z  = AW'(yv);
    for (int j = 0; j < K; j++) begin
      if (past_ok) begin
        c = coef_flat[((0*K + int'(row))*K + j)*W +: W];
        z = d_past[j] ? z + AW'(c) : z - AW'(c);
      end
      if (j != int'(row)) begin
        c = coef_flat[((1*K + int'(row))*K + j)*W +: W];
        z = d_cur[j] ? z + AW'(c) : z - AW'(c);
      end
      c = coef_flat[((2*K + int'(row))*K + j)*W +: W];
      z = d_next[j] ? z + AW'(c) : z - AW'(c);
    end
    neg = z[AW-1];
  end
endmodule

// File: rtl/pic_stage.sv
module pic_stage
  import pic_pkg::*;
#(
  parameter int K  = 4,
  parameter int W  = 12,
  localparam int IW = $clog2(K),
  localparam int AW = W + $clog2(3*K + 1),
  localparam int CW = $clog2(K + 2) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [K*W-1:0]  in_soft,
  input  logic [K-1:0]    in_dec,
  input  logic            cw_en,
  input  logic [1:0]      cw_blk,
  input  logic [IW-1:0]   cw_row,
  input  logic [IW-1:0]   cw_col,
  input  logic [W-1:0]    cw_data,
  output logic            out_valid,
  output logic [K-1:0]    out_dec
);
  // reset: asserted asynchronously, released after two clean edges
  logic rs0, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs0 <= 1'b0; rst_q <= 1'b0; end
    else        begin rs0 <= 1'b1; rst_q <= rs0;  end
  end

  // stream history and job snapshot
  logic [K*W-1:0] h_y, j_y;
  logic [K-1:0]   h_d, h_dp, j_dm, j_d0, j_dn;
  logic           h_have, h_pok, j_mok;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      h_y <= '0; h_d <= '0; h_dp <= '0; h_have <= 1'b0; h_pok <= 1'b0;
      j_y <= '0; j_dm <= '0; j_d0 <= '0; j_dn <= '0; j_mok <= 1'b0;
    end else if (in_valid) begin
      j_y <= h_y; j_dm <= h_dp; j_mok <= h_pok; j_d0 <= h_d; j_dn <= in_dec;
      h_dp <= h_d; h_pok <= h_have; h_d <= in_dec; h_y <= in_soft; h_have <= 1'b1;
    end
  end

  // coefficients
  logic [NBLK*K*K*W-1:0] coef_flat;
  logic                  busy;

  pic_coef_bank #(.K(K), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_q), .lock(busy | in_valid),
    .wr_en(cw_en), .wr_blk(cw_blk), .wr_row(cw_row), .wr_col(cw_col),
    .wr_data(cw_data), .coef_flat(coef_flat)
  );

  // one user per cycle
  logic [CW-1:0] cnt, cnt_n;
  logic [K-1:0]  res, res_n, od_n;
  logic          busy_n, ov_n, neg, start;

  pic_row_eval #(.K(K), .W(W), .AW(AW)) u_eval (
    .coef_flat(coef_flat), .row(cnt[IW-1:0]), .y_flat(j_y),
    .d_past(j_dm), .past_ok(j_mok), .d_cur(j_d0), .d_next(j_dn), .neg(neg)
  );

  assign start = in_valid & h_have;

  always_comb begin
    busy_n = busy; cnt_n = cnt; res_n = res; ov_n = 1'b0; od_n = out_dec;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy) begin
      cnt_n = cnt + CW'(1);
      if (cnt < CW'(K)) res_n[cnt[IW-1:0]] = neg;
      if (cnt == CW'(K + 1)) begin
        busy_n = 1'b0;
        ov_n   = 1'b1;
        od_n   = res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      busy <= 1'b0; cnt <= '0; res <= '0; out_valid <= 1'b0; out_dec <= '0;
    end else begin
      busy <= busy_n; cnt <= cnt_n; res <= res_n; out_valid <= ov_n; out_dec <= od_n;
    end
  end

  // R6, R8: input spacing the block relies on
  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> !busy);
  // R7: the first vector only fills history
  a_r7_first_silent: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !h_have) |=> !busy);
  // R6: single-cycle result pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |=> !out_valid);
  // R6: every result closes a running job
  a_r6_from_job: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(busy));
endmodule

// File: tb/pic_stage_bench.sv
module pic_stage_bench;
  localparam int K = 4;
  localparam int W = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [K*W-1:0] in_soft;
  logic [K-1:0]   in_dec;
  logic           cw_en;
  logic [1:0]     cw_blk;
  logic [1:0]     cw_row, cw_col;
  logic [W-1:0]   cw_data;
  logic           out_valid;
  logic [K-1:0]   out_dec;

  always #2.5 clk = ~clk;

  pic_stage #(.K(K), .W(W)) u_pic_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soft(in_soft), .in_dec(in_dec),
    .cw_en(cw_en), .cw_blk(cw_blk), .cw_row(cw_row), .cw_col(cw_col), .cw_data(cw_data),
    .out_valid(out_valid), .out_dec(out_dec)
  );

  int n_chk = 0, n_fail = 0;
  int cm [3][K][K];
  logic [K*W-1:0] by;
  logic [K-1:0]   bd, bdp;
  bit             bhave, bpok;

  localparam int TY [8][K] = '{
    '{ 300, -250,   40, -700}, '{-120,  500, -600,  200},
    '{  10,  -15,  900, -333}, '{-800,  640,  -90,   90},
    '{ 450,  450, -450, -450}, '{  -5,    5,  250, -260},
    '{2047, -2048,  77,  -77}, '{ 180, -180,  600,  -20}};
  localparam logic [K-1:0] TD [8] = '{4'b0000, 4'b1010, 4'b0111, 4'b1001,
                                      4'b1111, 4'b0100, 4'b0011, 4'b1100};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [K*W-1:0] pack_y(input int v0, v1, v2, v3);
    return {W'(v3), W'(v2), W'(v1), W'(v0)};
  endfunction

  function automatic logic [K-1:0] model(input logic [K*W-1:0] y, input logic [K-1:0] dm,
                                         input bit pok, input logic [K-1:0] d0, dn);
    logic [K-1:0] r;
    for (int k = 0; k < K; k++) begin
      int z;
      z = int'($signed(y[k*W +: W]));
      for (int j = 0; j < K; j++) begin
        if (pok)    z -= cm[0][k][j] * (dm[j] ? -1 : 1);
        if (j != k) z -= cm[1][k][j] * (d0[j] ? -1 : 1);
        z -= cm[2][k][j] * (dn[j] ? -1 : 1);
      end
      r[k] = (z < 0);
    end
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; cw_en = 1'b0; in_soft = '0; in_dec = '0;
    cw_blk = '0; cw_row = '0; cw_col = '0; cw_data = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_dec == '0, "R9 reset outputs", {out_valid, out_dec}, 0);
    for (int b = 0; b < 3; b++) for (int k = 0; k < K; k++) for (int j = 0; j < K; j++) cm[b][k][j] = 0;
    bhave = 1'b0; bpok = 1'b0; bd = '0; bdp = '0; by = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input int b, input int k, input int j, input int v);
    @(negedge clk);
    cw_en = 1'b1; cw_blk = 2'(b); cw_row = 2'(k); cw_col = 2'(j); cw_data = W'(v);
    @(negedge clk);
    cw_en = 1'b0;
    if (b < 3) cm[b][k][j] = v;
  endtask

  task automatic push(input logic [K*W-1:0] y, input logic [K-1:0] d, input bit wb, input string req);
    logic [K-1:0] e;
    bit ev;
    ev = bhave;
    e  = bhave ? model(by, bdp, bpok, bd, d) : '0;
    @(negedge clk);
    in_valid = 1'b1; in_soft = y; in_dec = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (wb) begin cw_en = 1'b1; cw_blk = 2'd1; cw_row = 2'd0; cw_col = 2'd1; cw_data = 12'h7FF; end
    repeat (K + 1) begin @(negedge clk); cw_en = 1'b0; end
    chk(out_valid == 1'b0, "R6 no early result", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == ev, ev ? "R6 result pulse" : "R7 first vector silent", int'(out_valid), int'(ev));
    if (ev) chk(out_dec == e, req, int'(out_dec), int'(e));
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 pulse width", int'(out_valid), 0);
    bdp = bd; bpok = bhave; bd = d; by = y; bhave = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R9 reset state, then streamed table with a mixed coefficient pattern
    do_reset();
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < K; k++)
        for (int j = 0; j < K; j++)
          wr(b, k, j, (((b*7 + k*5 + j*3) % 11) - 5) * 37);
    for (int n = 0; n < 8; n++)
      push(pack_y(TY[n][0], TY[n][1], TY[n][2], TY[n][3]), TD[n], 1'b0,
           n == 1 ? "R7 first bit without past" : "R1 R3 R4 R5 decision");

    // R2 own current-bit entry ignored; R1 zero decides +1
    do_reset();
    wr(1, 0, 0, 2047);
    wr(1, 1, 1, -2048);
    push(pack_y(100, -100, 0, 0), 4'b0000, 1'b0, "R2 setup");
    push(pack_y(0, 0, 0, 0), 4'b0000, 1'b0, "R2 R1 diagonal and zero tie");
    chk(out_dec == 4'b0010, "R2 R1 explicit", int'(out_dec), 2);

    // R8 code-3 write lands nowhere; write during a job dropped
    wr(3, 0, 1, 2047);
    push(pack_y(5, 0, 0, 0), 4'b0000, 1'b1, "R8 write while busy");
    chk(out_dec[0] == 1'b0, "R8 user0 unaffected", int'(out_dec[0]), 0);
    push(pack_y(5, 0, 0, 0), 4'b0000, 1'b0, "R8 store unchanged");
    chk(out_dec[0] == 1'b0, "R8 user0 still unaffected", int'(out_dec[0]), 0);

    // R4 next-bit block alone flips a decision
    do_reset();
    wr(2, 2, 3, 300);
    push(pack_y(0, 0, 200, 0), 4'b0000, 1'b0, "R4 setup");
    push(pack_y(0, 0, 0, 0), 4'b0000, 1'b0, "R4 next block");
    chk(out_dec[2] == 1'b1, "R4 explicit", int'(out_dec[2]), 1);

    // R3 past block including own column, R5 sign handling
    do_reset();
    wr(0, 1, 1, 400);
    push(pack_y(0, 100, 0, 0), 4'b0010, 1'b0, "R3 setup");
    push(pack_y(0, 100, 0, 0), 4'b0000, 1'b0, "R3 R7 bit0 ignores past");
    chk(out_dec[1] == 1'b0, "R7 explicit", int'(out_dec[1]), 0);
    push(pack_y(0, 0, 0, 0), 4'b0000, 1'b0, "R3 R5 past term");
    chk(out_dec[1] == 1'b0, "R3 R5 explicit", int'(out_dec[1]), 0);

    // R10 full-scale sums
    do_reset();
    for (int b = 0; b < 3; b++) for (int k = 0; k < K; k++) for (int j = 0; j < K; j++) wr(b, k, j, -2048);
    for (int n = 0; n < 3; n++) push(pack_y(-2048, -2048, -2048, -2048), 4'b1111, 1'b0, "R10 negative extreme");
    chk(out_dec == 4'b1111, "R10 explicit negative", int'(out_dec), 15);
    do_reset();
    for (int b = 0; b < 3; b++) for (int k = 0; k < K; k++) for (int j = 0; j < K; j++) wr(b, k, j, -2048);
    for (int n = 0; n < 3; n++) push(pack_y(2047, 2047, 2047, 2047), 4'b0000, 1'b0, "R10 positive extreme");
    chk(out_dec == 4'b0000, "R10 explicit positive", int'(out_dec), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule